// File: doc/BRIEF.md
# Prioritized Interrupt Controller

The block gathers a parameterized set of interrupt inputs (64 by default) and drives one IRQ line toward a single processor. Each input carries an enable bit, a priority whose upper five bits are stored, and a sensitivity mode: level-high or rising-edge. The lowest IDs, 16 by default, are the software-generated sources, which are always edge-sensitive. A global forwarding enable, a two-bit processor-side enable and an 8-bit priority mask gate the line.

Software uses a 32-bit, word-aligned register port. Reading the acknowledge register selects the most urgent eligible interrupt, returns its ID and marks it active. Writing that ID to the end-of-interrupt register retires it. Active interrupts set a running priority, so only a more urgent request can interrupt the handler. A separate register shows the top pending ID and has no side effect. A read returns its data one cycle after the request, with `rd_valid`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every enable, priority, mask and control bit is zero, `irq` is low and an acknowledge read returns 1023.
- R2: A write to 0x100+4k sets enable of source 32k+b for each 1 in bit b; a write to 0x180+4k clears it; 0 bits have no effect; both addresses read back the enable word.
- R3: Priority of source n sits in byte n%4 of word 0x400+4*(n/4); bits [7:3] of the byte are stored and bits [2:0] read as zero; 0 is most urgent.
- R4: Sensitivity of source n sits in bits [2m+1:2m] of word 0xC00+4*(n/16), m=n%16; 01 selects level-high (reset value), 11 selects rising edge; sources below NUM_SGI read 10, ignore writes and are edge-sensitive.
- R5: `irq` is high only when bit 0 of 0x000 is 1, bits [1:0] of 0x004 are 11, and an enabled, pending, non-active source has priority numerically below the mask at 0x008 bits [7:0].
- R6: A read of 0x00C, while `irq` is high, returns the ID of the most urgent eligible source (lowest ID on equal priority), marks it active and clears its latched edge.
- R7: A read of 0x00C while `irq` is low returns 1023 and changes no state.
- R8: A write of an ID to bits [9:0] of 0x010 retires that active interrupt; a different ID leaves it active.
- R9: A level source whose input is still high is pending again after it is retired.
- R10: An edge source latches a rising edge, stays pending after the input falls, and is not pending again after retirement without a new edge.
- R11: A read of 0x014 returns the ID of the most urgent enabled, pending, non-active source (1023 if none), ignoring mask and enables of 0x000/0x004, with no side effect.
- R12: While an interrupt is active, `irq` rises only for a source strictly more urgent than the most urgent active one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NUM_SRC | Interrupt inputs, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Read data, including the acknowledge side effect, appears one edge after the read strobe. The scoreboard monitor therefore pops an expected value at the falling edge following the capturing rising edge. Register writes, acknowledges, retirements and input changes all act on `irq` after the next rising edge. The bench changes inputs on a falling edge and then checks `irq` just after the following falling edge. Edge sources are pulsed for exactly one cycle to show that the latch, not the input level, holds the request.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC = 64,
  parameter int NUM_SGI = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [11:0]        addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               rd_valid,
  output logic               irq
);
  localparam int SET_BASE = 64;
  localparam int CLR_BASE = 96;
  localparam int PRI_BASE = 256;
  localparam int CFG_BASE = 768;
  localparam int A_DIST = 0, A_CPU = 1, A_MASK = 2, A_ACK = 3, A_EOI = 4, A_HIP = 5;
  localparam logic [9:0] SPUR = 10'd1023;

  logic [NUM_SRC-1:0] en_v, edge_q, edge_m, src_q, pend_e, pend, act, elig;
  logic [4:0]  pri_v [NUM_SRC];
  logic        dist_en;
  logic [1:0]  cpu_ctrl;
  logic [7:0]  pmask;
  logic        best_valid, run_valid, grant_ok;
  logic [4:0]  best_pri, run_pri;
  logic [9:0]  best_id;
  logic [31:0] rd_next;

  wire        aligned = addr[1:0] == 2'b00;
  wire [31:0] widx    = 32'(addr[11:2]);
  wire        wr      = wr_en && aligned;
  wire        rd      = rd_en && aligned;
  wire        ack_take = rd && widx == A_ACK && grant_ok;
  wire        eoi_wr   = wr && widx == A_EOI;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      edge_m[i] = (i < NUM_SGI) ? 1'b1 : edge_q[i];
      pend[i]   = edge_m[i] ? pend_e[i] : src_q[i];
    end
  end
  assign elig = pend & en_v & ~act;

  always_comb begin
    best_valid = 1'b0; best_pri = 5'd31; best_id = SPUR;
    run_valid  = 1'b0; run_pri  = 5'd31;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!best_valid || pri_v[i] < best_pri)) begin
        best_valid = 1'b1; best_pri = pri_v[i]; best_id = 10'(i);
      end
      if (act[i] && (!run_valid || pri_v[i] < run_pri)) begin
        run_valid = 1'b1; run_pri = pri_v[i];
      end
    end
  end

  assign grant_ok = dist_en && (&cpu_ctrl) && best_valid && ({best_pri, 3'b000} < pmask)
                    && (!run_valid || best_pri < run_pri);
  assign irq = grant_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_en <= 1'b0; cpu_ctrl <= 2'b00; pmask <= 8'h00;
    end else if (wr) begin
      if (widx == A_DIST) dist_en  <= wdata[0];
      if (widx == A_CPU)  cpu_ctrl <= wdata[1:0];
      if (widx == A_MASK) pmask    <= wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_v <= '0; edge_q <= '0; src_q <= '0; pend_e <= '0; act <= '0;
      for (int i = 0; i < NUM_SRC; i++) pri_v[i] <= 5'd0;
    end else begin
      src_q <= src_in;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (wr && widx == SET_BASE + i/32 && wdata[i%32]) en_v[i] <= 1'b1;
        if (wr && widx == CLR_BASE + i/32 && wdata[i%32]) en_v[i] <= 1'b0;
        if (wr && widx == PRI_BASE + i/4) pri_v[i] <= wdata[(i%4)*8+3 +: 5];
        if (wr && widx == CFG_BASE + i/16 && i >= NUM_SGI) edge_q[i] <= wdata[(i%16)*2+1];
        if (!edge_m[i])
          pend_e[i] <= 1'b0;
        else if (src_in[i] && !src_q[i])
          pend_e[i] <= 1'b1;
        else if (ack_take && int'(best_id) == i)
          pend_e[i] <= 1'b0;
        if (ack_take && int'(best_id) == i)
          act[i] <= 1'b1;
        else if (eoi_wr && int'(wdata[9:0]) == i)
          act[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_next = 32'd0;
    case (widx)
      A_DIST:  rd_next[0]   = dist_en;
      A_CPU:   rd_next[1:0] = cpu_ctrl;
      A_MASK:  rd_next[7:0] = pmask;
      A_ACK:   rd_next[9:0] = grant_ok ? best_id : SPUR;
      A_HIP:   rd_next[9:0] = best_id;
      default: ;
    endcase
    for (int i = 0; i < NUM_SRC; i++) begin
      if (widx == SET_BASE + i/32 || widx == CLR_BASE + i/32) rd_next[i%32] = en_v[i];
      if (widx == PRI_BASE + i/4) rd_next[(i%4)*8 +: 8] = {pri_v[i], 3'b000};
      if (widx == CFG_BASE + i/16)
        rd_next[(i%16)*2 +: 2] = (i < NUM_SGI) ? 2'b10 : {edge_q[i], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 32'd0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd;
      if (rd) rdata <= rd_next;
    end
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [11:0]        addr,
  input logic [31:0]        rdata,
  input logic               rd_valid,
  input logic               irq,
  input logic               dist_en,
  input logic [1:0]         cpu_ctrl,
  input logic [7:0]         pmask,
  input logic [NUM_SRC-1:0] act
);
  wire ack_rd = rd_en && addr == 12'h00C;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (dist_en && cpu_ctrl == 2'b11 && pmask != 8'h00));
  a_r6_ack_id: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq) |=> (rd_valid && rdata < 32'(NUM_SRC)));
  a_r6_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq && !wr_en) |=> $countones(act) == $past($countones(act)) + 1);
  a_r7_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq) |=> (rd_valid && rdata == 32'd1023));
  a_r7_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq && !wr_en) |=> $stable(act));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .rd_valid(rd_valid), .irq(irq), .dist_en(dist_en),
  .cpu_ctrl(cpu_ctrl), .pmask(pmask), .act(act)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int N = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rd_valid, irq;
  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .NUM_SGI(16)) i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irq(irq));

  always @(negedge clk) begin
    if (rd_valid) begin
      logic [31:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++; $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++; $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_src(input int n, input logic v);
    @(negedge clk); src_in[n] = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    #1; checks++;
    if (irq !== e) begin
      errors++; $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(1'b0, "R1 reset irq");
    rd(12'h00C, 32'd1023, "R1 ack after reset");
    rd(12'h100, 32'h0, "R1 enables reset");
    rd(12'h008, 32'h0, "R1 mask reset");
    // R2 enable banks
    wr(12'h104, 32'h0010_0001);
    rd(12'h104, 32'h0010_0001, "R2 set-enable readback");
    rd(12'h184, 32'h0010_0001, "R2 clear-enable readback");
    wr(12'h104, 32'h0);
    rd(12'h104, 32'h0010_0001, "R2 zero write ignored");
    wr(12'h184, 32'h1);
    rd(12'h104, 32'h0010_0000, "R2 clear bit 0");
    // R3 priorities
    wr(12'h434, 32'hFFFF_FFFF);
    rd(12'h434, 32'hF8F8_F8F8, "R3 low bits read zero");
    wr(12'h434, 32'h0000_00A7);
    rd(12'h434, 32'h0000_00A0, "R3 source 52 priority");
    // R4 sensitivity
    rd(12'hC00, 32'hAAAA_AAAA, "R4 sgi fields");
    wr(12'hC00, 32'h5555_5555);
    rd(12'hC00, 32'hAAAA_AAAA, "R4 sgi fields read-only");
    rd(12'hC0C, 32'h5555_5555, "R4 level reset");
    wr(12'hC0C, 32'h5555_5755);
    rd(12'hC0C, 32'h5555_5755, "R4 edge field write");
    wr(12'hC0C, 32'h5555_5555);
    // R5 gating
    set_src(52, 1'b1);
    chk_irq(1'b0, "R5 all gates closed");
    wr(12'h008, 32'hFF); wr(12'h004, 32'h3);
    chk_irq(1'b0, "R5 distributor off");
    wr(12'h000, 32'h1);
    chk_irq(1'b1, "R5 all gates open");
    wr(12'h008, 32'hA0);
    chk_irq(1'b0, "R5 mask equal to priority");
    wr(12'h008, 32'hA1);
    chk_irq(1'b1, "R5 mask above priority");
    wr(12'h004, 32'h1);
    chk_irq(1'b0, "R5 cpu ctrl one bit");
    wr(12'h004, 32'h3);
    // R11 highest pending
    rd(12'h014, 32'd52, "R11 hipend");
    chk_irq(1'b1, "R11 no side effect");
    rd(12'h014, 32'd52, "R11 hipend again");
    // R6 acknowledge
    rd(12'h00C, 32'd52, "R6 ack 52");
    chk_irq(1'b0, "R6 active blocks irq");
    rd(12'h014, 32'd1023, "R11 none pending");
    // R12 preemption
    src_in[53] = 1'b1;
    wr(12'h104, 32'h0020_0000);
    chk_irq(1'b1, "R12 more urgent preempts");
    rd(12'h00C, 32'd53, "R12 ack 53");
    set_src(53, 1'b0);
    wr(12'h010, 32'd53);
    chk_irq(1'b0, "R8 retire 53");
    wr(12'h420, 32'h0000_00A0);
    src_in[32] = 1'b1;
    wr(12'h104, 32'h1);
    chk_irq(1'b0, "R12 equal priority blocked");
    wr(12'h010, 32'd52);
    chk_irq(1'b1, "R9 after retire");
    rd(12'h00C, 32'd32, "R6 tie lower id");
    set_src(32, 1'b0);
    wr(12'h010, 32'd32);
    rd(12'h00C, 32'd52, "R9 level re-pending");
    set_src(52, 1'b0);
    wr(12'h010, 32'd52);
    chk_irq(1'b0, "R9 idle after drop");
    // R10 edge source 40
    wr(12'hC08, 32'h5557_5555);
    wr(12'h428, 32'h10);
    wr(12'h104, 32'h100);
    @(negedge clk); src_in[40] = 1'b1;
    @(negedge clk); src_in[40] = 1'b0;
    chk_irq(1'b1, "R10 edge latched");
    rd(12'h00C, 32'd40, "R10 ack 40");
    wr(12'h010, 32'd40);
    chk_irq(1'b0, "R10 no re-pend");
    // R7 spurious, R8 wrong id
    set_src(52, 1'b1);
    wr(12'h008, 32'h0);
    chk_irq(1'b0, "R7 masked");
    rd(12'h00C, 32'd1023, "R7 spurious");
    wr(12'h008, 32'hA1);
    chk_irq(1'b1, "R7 state unchanged");
    rd(12'h00C, 32'd52, "R6 ack 52 again");
    wr(12'h010, 32'd53);
    chk_irq(1'b0, "R8 wrong id keeps active");
    rd(12'h014, 32'd1023, "R8 still active");
    wr(12'h010, 32'd52);
    chk_irq(1'b1, "R8 right id retires");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule